// File: doc/BRIEF.md
# Video Lock Status Hysteresis Filter

This block turns the raw, per-line lock indications of a video decoder into a steady "locked" flag. Raw lock must hold for a programmable number of consecutive video lines before the flag rises. It must then stay absent for a second, independently programmed number of consecutive lines before the flag falls. Both numbers are picked by 3-bit codes from a fixed, nonlinear table, so short bursts of noise neither raise nor drop the status.

The raw lock can be defined two ways. It can come from horizontal lock alone, or it can require horizontal and subcarrier lock together. It can be judged line by line, or it can be sampled once per field and held for every line of that field. The filter advances only on a line strobe. It reports edges of the filtered flag as single-cycle pulses, one for lock acquired and one for lock lost.

Top module: `lock_hyst_filter`

## Requirements
- R1: The lock-in code `in_code` selects a threshold of N consecutive raw-locked line strobes. The codes 0..7 give N = 1, 2, 5, 10, 100, 500, 1000 and 100000.
- R2: The lock-out code `out_code` is independent of `in_code` and uses the same eight-entry table to give M consecutive raw-unlocked line strobes.
- R3: `locked` rises only when raw lock has been present on N consecutive line strobes. A strobe without raw lock restarts that run.
- R4: `locked` falls only when raw lock has been absent on M consecutive line strobes. A strobe with raw lock restarts that run.
- R5: When `sc_lock_en` is 0, raw lock equals `hlock_in`. When it is 1, raw lock is `hlock_in` AND `sclock_in`.
- R6: When `field_mode` is 1, raw lock is the value sampled on the last cycle with `field_stb` high, and it is held until the next field strobe. After reset the held value is 0. When `field_mode` is 0, the current value is used.
- R7: Run counters change only on cycles with `line_stb` high. They saturate at their threshold. A strobe of the opposite raw state clears a counter to 0.
- R8: Reset (`rst_n` low, synchronous) forces `locked`, `acq_pulse`, `lost_pulse` and both counters to 0.
- R9: A change of either code takes effect on the next line strobe and does not by itself change `locked`. A count already above a newly lowered threshold completes the run on that next strobe.
- R10: `acq_pulse` is high for exactly the one cycle in which `locked` first reads 1. `lost_pulse` is high for exactly the one cycle in which `locked` first reads 0. The two are never high together.
- R11: `locked` and both pulses are registered. They change on the clock edge that samples the qualifying `line_stb`, and on no other edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| line_stb | input | 1 | One-cycle strobe per video line |
| field_stb | input | 1 | One-cycle strobe per field boundary |
| hlock_in | input | 1 | Raw horizontal lock |
| sclock_in | input | 1 | Raw subcarrier lock |
| sc_lock_en | input | 1 | 1: raw lock also needs subcarrier lock |
| field_mode | input | 1 | 1: raw lock sampled per field; 0: per line |
| in_code | input | 3 | Lock-in threshold code |
| out_code | input | 3 | Lock-out threshold code |
| locked | output | 1 | Filtered lock status |
| acq_pulse | output | 1 | One-cycle pulse on lock acquired |
| lost_pulse | output | 1 | One-cycle pulse on lock lost |

## Verification
On every cycle the assertions check counter discipline: counts hold between strobes, clear on an opposite strobe, and never exceed the threshold that was in force. They also check that the flag moves only after a strobe and that the pulses line up with its edges. Some behaviour only the bench scenarios can show. These are the exact line counts behind each code, the restart of a run after a single contrary line, the field-hold behaviour, the subcarrier qualification, and the fact that a code change leaves the flag alone until the next line.

// File: rtl/lock_hyst_pkg.sv
// Package: shared constants and the threshold table for the lock filter.
// Assumes thresholds fit in CNT_W bits (largest entry 100000 needs 17).
package lock_hyst_pkg;

    localparam int CNT_W  = 17;
    localparam int CODE_W = 3;

    // Map a 3-bit code to a line count (nonlinear table).
    function automatic logic [CNT_W-1:0] code_to_lines(input logic [CODE_W-1:0] code);
        logic [CNT_W-1:0] n;
        case (code)
            3'd0:    n = CNT_W'(1);
            3'd1:    n = CNT_W'(2);
            3'd2:    n = CNT_W'(5);
            3'd3:    n = CNT_W'(10);
            3'd4:    n = CNT_W'(100);
            3'd5:    n = CNT_W'(500);
            3'd6:    n = CNT_W'(1000);
            default: n = CNT_W'(100000);
        endcase
        return n;
    endfunction

endpackage

// File: rtl/lock_code_decode.sv
// Module: combinational decoder from a threshold code to a line count.
// Assumes the code is stable or changes only between line strobes of interest.
module lock_code_decode
    import lock_hyst_pkg::*;
(
    input  logic [CODE_W-1:0] code,
    output logic [CNT_W-1:0]  lines
);

    // Look up the line count for the code.
    always_comb begin
        lines = code_to_lines(code);
    end

endmodule

// File: rtl/lock_raw_select.sv
// Module: forms the raw lock bit from horizontal and subcarrier lock and
// optionally holds a per-field sample of it.
// Assumes field_stb is one cycle wide per field boundary.
module lock_raw_select (
    input  logic clk,
    input  logic rst_n,
    input  logic field_stb,
    input  logic hlock_in,
    input  logic sclock_in,
    input  logic sc_lock_en,
    input  logic field_mode,
    output logic raw_lock
);

    logic raw_now;
    logic raw_held;

    // Qualify horizontal lock with subcarrier lock when enabled.
    always_comb begin
        raw_now = hlock_in & (sclock_in | ~sc_lock_en);
    end

    // Capture the raw value at each field boundary.
    always_ff @(posedge clk) begin
        if (!rst_n)         raw_held <= 1'b0;
        else if (field_stb) raw_held <= raw_now;
    end

    // Choose per-line or per-field evaluation.
    always_comb begin
        raw_lock = field_mode ? raw_held : raw_now;
    end

    AST_HELD_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
        !field_stb |=> $stable(raw_held)); // R6

endmodule

// File: rtl/lock_run_counter.sv
// Module: saturating run counter of line strobes on which "match" holds.
// A strobe with match low clears the run. hit flags the strobe that makes
// the run reach the threshold. Assumes thr >= 1.
module lock_run_counter
    import lock_hyst_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             adv,
    input  logic             match,
    input  logic [CNT_W-1:0] thr,
    output logic [CNT_W-1:0] cnt,
    output logic             hit
);

    logic [CNT_W:0] inc;
    logic           reach;

    // Widened increment and threshold compare.
    always_comb begin
        inc   = {1'b0, cnt} + 1'b1;
        reach = (inc >= {1'b0, thr});
        hit   = adv & match & reach;
    end

    // Advance, saturate or clear on the line strobe only.
    always_ff @(posedge clk) begin
        if (!rst_n)     cnt <= '0;
        else if (adv) begin
            if (!match)     cnt <= '0;
            else if (reach) cnt <= thr;
            else            cnt <= inc[CNT_W-1:0];
        end
    end

    AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
        adv |=> cnt <= $past(thr)); // R7
    AST_CLEAR_ON_OPPOSITE: assert property (@(posedge clk) disable iff (!rst_n)
        (adv && !match) |=> cnt == '0); // R7
    AST_HOLD_NO_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
        !adv |=> $stable(cnt)); // R7

endmodule

// File: rtl/lock_hyst_filter.sv
// Module: top of the lock hysteresis filter. Two run counters (lock-in and
// lock-out) with decoded thresholds drive a registered status flag and
// single-cycle edge pulses. Assumes line_stb and field_stb are synchronous.
module lock_hyst_filter
    import lock_hyst_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              line_stb,
    input  logic              field_stb,
    input  logic              hlock_in,
    input  logic              sclock_in,
    input  logic              sc_lock_en,
    input  logic              field_mode,
    input  logic [CODE_W-1:0] in_code,
    input  logic [CODE_W-1:0] out_code,
    output logic              locked,
    output logic              acq_pulse,
    output logic              lost_pulse
);

    localparam int NRUN = 2;   // index 0: lock-in run, 1: lock-out run

    logic                raw_lock;
    logic [CODE_W-1:0]   codes [NRUN];
    logic [CNT_W-1:0]    thr   [NRUN];
    logic [CNT_W-1:0]    cnt   [NRUN];
    logic [NRUN-1:0]     match;
    logic [NRUN-1:0]     hit;
    logic                set_c;
    logic                clr_c;

    lock_raw_select u_raw (
        .clk        (clk),
        .rst_n      (rst_n),
        .field_stb  (field_stb),
        .hlock_in   (hlock_in),
        .sclock_in  (sclock_in),
        .sc_lock_en (sc_lock_en),
        .field_mode (field_mode),
        .raw_lock   (raw_lock)
    );

    // Route codes and run polarity to the two counters.
    always_comb begin
        codes[0] = in_code;
        codes[1] = out_code;
        match[0] = raw_lock;
        match[1] = ~raw_lock;
    end

    for (genvar g = 0; g < NRUN; g++) begin : g_run
        lock_code_decode u_dec (
            .code  (codes[g]),
            .lines (thr[g])
        );
        lock_run_counter u_cnt (
            .clk   (clk),
            .rst_n (rst_n),
            .adv   (line_stb),
            .match (match[g]),
            .thr   (thr[g]),
            .cnt   (cnt[g]),
            .hit   (hit[g])
        );
    end

    // Status transitions on a completed run.
    always_comb begin
        set_c = hit[0] & ~locked;
        clr_c = hit[1] &  locked;
    end

    // Register the status and its edge pulses.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            locked     <= 1'b0;
            acq_pulse  <= 1'b0;
            lost_pulse <= 1'b0;
        end else begin
            if (set_c)      locked <= 1'b1;
            else if (clr_c) locked <= 1'b0;
            acq_pulse  <= set_c;
            lost_pulse <= clr_c;
        end
    end

    AST_CHANGE_ON_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(locked) |-> $past(line_stb)); // R11
    AST_ACQ_EDGE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(locked) |-> acq_pulse); // R10
    AST_LOST_EDGE: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(locked) |-> lost_pulse); // R10
    AST_PULSE_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({acq_pulse, lost_pulse})); // R10
    AST_PULSE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        acq_pulse |=> !acq_pulse); // R10

endmodule

// File: tb/lock_hyst_filter_test.sv
module lock_hyst_filter_test;

    localparam int CLK_PERIOD = 10;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       line_stb = 1'b0, field_stb = 1'b0;
    logic       hlock_in = 1'b0, sclock_in = 1'b0;
    logic       sc_lock_en = 1'b0, field_mode = 1'b0;
    logic [2:0] in_code = 3'd0, out_code = 3'd0;
    logic       locked, acq_pulse, lost_pulse;

    int n_chk = 0;
    int n_bad = 0;
    bit done  = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    lock_hyst_filter uut (
        .clk(clk), .rst_n(rst_n), .line_stb(line_stb), .field_stb(field_stb),
        .hlock_in(hlock_in), .sclock_in(sclock_in), .sc_lock_en(sc_lock_en),
        .field_mode(field_mode), .in_code(in_code), .out_code(out_code),
        .locked(locked), .acq_pulse(acq_pulse), .lost_pulse(lost_pulse)
    );

    typedef struct packed {
        logic       hl;
        logic       sc;
        logic       en;
        logic [2:0] ic;
        logic [2:0] oc;
        logic [9:0] n;
        logic       exp;
    } row_t;

    // Vectors applied in order from reset: raw inputs, codes, strobes, expected flag.
    localparam int NROW = 16;
    localparam row_t TBL [NROW] = '{
        '{1'b1,1'b0,1'b0,3'd3,3'd2,10'd9,  1'b0},  // R3 10 lines: 9 not enough
        '{1'b1,1'b0,1'b0,3'd3,3'd2,10'd1,  1'b1},  // R1 R3 10th line locks
        '{1'b0,1'b0,1'b0,3'd3,3'd2,10'd4,  1'b1},  // R4 5 lines: 4 not enough
        '{1'b0,1'b0,1'b0,3'd3,3'd2,10'd1,  1'b0},  // R2 R4 5th line drops
        '{1'b1,1'b0,1'b1,3'd0,3'd1,10'd20, 1'b0},  // R5 no subcarrier lock
        '{1'b1,1'b1,1'b1,3'd0,3'd1,10'd1,  1'b1},  // R5 R1 code 0 = 1 line
        '{1'b1,1'b0,1'b1,3'd0,3'd1,10'd1,  1'b1},  // R2 code 1 = 2 lines
        '{1'b1,1'b0,1'b1,3'd0,3'd1,10'd1,  1'b0},  // R2 second line drops
        '{1'b1,1'b0,1'b0,3'd2,3'd1,10'd4,  1'b0},  // R3 code 2 = 5 lines
        '{1'b0,1'b0,1'b0,3'd2,3'd1,10'd1,  1'b0},  // R3 interrupt restarts
        '{1'b1,1'b0,1'b0,3'd2,3'd1,10'd4,  1'b0},  // R3 restarted run short
        '{1'b1,1'b0,1'b0,3'd2,3'd4,10'd1,  1'b1},  // R3 fifth line locks
        '{1'b0,1'b0,1'b0,3'd2,3'd4,10'd99, 1'b1},  // R2 code 4 = 100 lines
        '{1'b0,1'b0,1'b0,3'd2,3'd4,10'd1,  1'b0},  // R2 100th drops
        '{1'b1,1'b0,1'b0,3'd5,3'd4,10'd499,1'b0},  // R1 code 5 = 500 lines
        '{1'b1,1'b0,1'b0,3'd5,3'd4,10'd1,  1'b1}   // R1 500th locks
    };

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    // Hold line_stb high for n consecutive rising edges; return at a falling edge.
    task automatic lines(input int n);
        @(negedge clk) line_stb = 1'b1;
        repeat (n - 1) @(negedge clk);
        @(negedge clk) line_stb = 1'b0;
    endtask

    task automatic do_reset();
        @(negedge clk) rst_n = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
    endtask

    initial begin
        // R8: strobes with lock during reset have no effect
        hlock_in = 1'b1; line_stb = 1'b1;
        repeat (3) @(negedge clk);
        chk("R8 locked in reset", locked, 0);
        chk("R8 acq in reset", acq_pulse, 0);
        chk("R8 lost in reset", lost_pulse, 0);
        line_stb = 1'b0; hlock_in = 1'b0;
        rst_n = 1'b1;

        for (int i = 0; i < NROW; i++) begin
            @(negedge clk);
            hlock_in = TBL[i].hl; sclock_in = TBL[i].sc; sc_lock_en = TBL[i].en;
            in_code = TBL[i].ic; out_code = TBL[i].oc;
            lines(int'(TBL[i].n));
            chk($sformatf("R3/R4 row %0d", i), locked, TBL[i].exp);
        end

        // R10 R11: pulse timing on acquisition and loss
        do_reset();
        in_code = 3'd0; out_code = 3'd0; sc_lock_en = 1'b0; hlock_in = 1'b1;
        repeat (4) @(negedge clk);
        chk("R11 no change without strobe", locked, 0);
        lines(1);
        chk("R10 acq high", acq_pulse, 1);
        chk("R10 locked with acq", locked, 1);
        @(negedge clk);
        chk("R10 acq one cycle", acq_pulse, 0);
        hlock_in = 1'b0;
        lines(1);
        chk("R10 lost high", lost_pulse, 1);
        chk("R10 unlocked with lost", locked, 0);
        @(negedge clk);
        chk("R10 lost one cycle", lost_pulse, 0);

        // R7: counter advances only on strobes
        in_code = 3'd1; hlock_in = 1'b1;
        lines(1);
        repeat (20) @(negedge clk);
        chk("R7 no count without strobe", locked, 0);
        lines(1);
        chk("R7 second strobe locks", locked, 1);

        // R9: code change does not disturb status; lowered threshold completes
        in_code = 3'd7;
        repeat (3) @(negedge clk);
        lines(2);
        chk("R9 in_code change keeps lock", locked, 1);
        out_code = 3'd3; hlock_in = 1'b0;
        lines(3);
        chk("R9 three of ten unlocked", locked, 1);
        out_code = 3'd1;
        @(negedge clk);
        chk("R9 code change alone", locked, 1);
        lines(1);
        chk("R9 lowered threshold drops", locked, 0);

        // R6: field-held raw lock
        do_reset();
        field_mode = 1'b1; in_code = 3'd0; out_code = 3'd0; hlock_in = 1'b1;
        lines(1);
        chk("R6 held value zero after reset", locked, 0);
        @(negedge clk) field_stb = 1'b1;
        @(negedge clk) field_stb = 1'b0; hlock_in = 1'b0;
        lines(3);
        chk("R6 held lock across field", locked, 1);
        @(negedge clk) field_stb = 1'b1;
        @(negedge clk) field_stb = 1'b0; hlock_in = 1'b1;
        lines(1);
        chk("R6 new field sample unlocked", locked, 0);
        field_mode = 1'b0;

        // R8: reset while locked clears status
        lines(1);
        chk("R8 relock before reset", locked, 1);
        do_reset();
        chk("R8 reset clears lock", locked, 0);

        // R1: code 6 = 1000 and code 7 = 100000 lines
        in_code = 3'd6; out_code = 3'd7; hlock_in = 1'b1;
        lines(999);
        chk("R1 code 6 999 lines", locked, 0);
        lines(1);
        chk("R1 code 6 1000 lines", locked, 1);
        hlock_in = 1'b0;
        lines(99999);
        chk("R2 code 7 99999 lines", locked, 1);
        lines(1);
        chk("R2 code 7 100000 lines", locked, 0);

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (190000) @(posedge clk);
        if (!done) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

endmodule